// File: doc/BRIEF.md
# Pipeline Converter Code Alignment and Redundancy Correction

This block sits behind a pipelined analog-to-digital converter built from 1.5-bit stages followed by one final single-comparator stage. Each redundant stage resolves its input against two thresholds, at a quarter of the reference above and below zero, and reports one of three codes. Its residue goes on to the next stage, which works on it one clock later. For any one sample, the codes therefore reach the block spread over consecutive clocks.

The block holds each stage's code and valid flag in a short shift register. The delay shrinks by one clock per stage, so the whole set for one sample reaches the adder in the same cycle as the final comparator bit. It then adds the codes with a one-bit overlap between neighbours. Because of this redundancy, a comparator that is off by up to a quarter of the reference still yields the correct word. A new word can leave every clock, with a fixed latency.

Stage codes of 11 cannot come from a healthy stage. The block flags them and gives them the weight of 10. A narrower output width may be configured, and sums that do not fit then clamp to all ones.

Top module: `pipe_adc_aligner`

## Requirements
- R1: Stage i (0..NSTG-1) puts its code on stg_code[2i+1:2i]. Codes 00, 01 and 10 weigh 0, 1 and 2 times 2^(NSTG-1-i). The final comparator bit fin_bit weighs 1. word_out is the sum of all these terms.
- R2: Suppose every 1.5-bit comparator threshold lies within VREF/4 of its ideal ±VREF/4 and the final comparator sits at zero. Then a valid word equals 2^NSTG − 1 + ceil(vin·2^NSTG/VREF) for an input vin in the open range (−VREF, VREF).
- R3: Take a sample whose stage 0 code is presented in cycle s. Its stage i code must arrive in cycle s+i and its final bit in cycle s+NSTG. The word becomes visible right after the clock edge that ends cycle s+NSTG.
- R4: Samples presented back to back give one valid word on every clock, with no gaps.
- R5: word_vld is high only when all NSTG+1 valid bits that travelled with the sample's codes (stg_vld[i] for stage i, stg_vld[NSTG] for the final bit) were high.
- R6: While word_vld is low, word_out and code_err are both zero.
- R7: A stage code of 11 raises code_err together with the valid word that contains it, and it counts as 10 in the sum.
- R8: If OUT_W is smaller than NSTG+1 and the sum reaches 2^OUT_W or more, word_out is all ones.
- R9: While rst_n is low, all outputs are zero. Reset also clears every code in flight, so no word formed from inputs presented before reset can appear afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stg_code | input | 2*NSTG | Codes of the 1.5-bit stages, stage i at bits 2i+1:2i |
| fin_bit | input | 1 | Decision of the final single-comparator stage |
| stg_vld | input | NSTG+1 | Valid per stage; bit NSTG belongs to fin_bit |
| word_out | output | OUT_W | Corrected output word |
| word_vld | output | 1 | Output word is valid |
| code_err | output | 1 | The valid word contained an illegal 11 code |

## Verification
The assertions assume that the valid flag of the final bit marks the last piece of a sample. They also assume that a stage code of 11 can appear only when a stage has failed. The bench models the analog stages in integer arithmetic, with a random offset on each comparator kept strictly inside a quarter of the reference. Inputs are odd multiples of the model's smallest step, so no residue ever lands exactly on a decision boundary and the expected word is unique. Illegal codes, dropped valid bits and a narrow-output instance are fed in separately, together with a reset applied while samples are in flight.

// File: rtl/pipe_adc_align_pkg.sv
`timescale 1ns/1ps
package pipe_adc_align_pkg;

  typedef logic [1:0] stg_code_t;

  localparam stg_code_t CODE_LOW  = 2'b00;
  localparam stg_code_t CODE_MID  = 2'b01;
  localparam stg_code_t CODE_HIGH = 2'b10;
  localparam stg_code_t CODE_BAD  = 2'b11;

  // An unreachable code is given the heaviest legal weight.
  function automatic stg_code_t fold_code(input stg_code_t c);
    return (c == CODE_BAD) ? CODE_HIGH : c;
  endfunction

  function automatic logic code_is_bad(input stg_code_t c);
    return c == CODE_BAD;
  endfunction

endpackage

// File: rtl/pipe_adc_skew_line.sv
`timescale 1ns/1ps
module pipe_adc_skew_line #(
  parameter int DEPTH = 1,
  parameter int W     = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] tap_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) tap_q[k] <= '0;
    end else begin
      tap_q[0] <= din;
      for (int k = 1; k < DEPTH; k++) tap_q[k] <= tap_q[k-1];
    end
  end

  assign dout = tap_q[DEPTH-1];

endmodule

// File: rtl/pipe_adc_code_fold.sv
`timescale 1ns/1ps
module pipe_adc_code_fold
  import pipe_adc_align_pkg::*;
(
  input  logic [1:0] raw,
  output logic [1:0] folded,
  output logic       bad
);

  assign folded = fold_code(raw);
  assign bad    = code_is_bad(raw);

endmodule

// File: rtl/pipe_adc_overlap_sum.sv
`timescale 1ns/1ps
module pipe_adc_overlap_sum #(
  parameter int NSTG  = 8,
  parameter int OUT_W = NSTG + 1
) (
  input  logic [2*NSTG-1:0] codes,
  input  logic              fin,
  output logic [OUT_W-1:0]  sum_out,
  output logic              ovf
);

  localparam int SUM_W = NSTG + 1;

  // Neighbouring stage codes overlap by one bit; the final bit lands at weight 1.
  function automatic logic [SUM_W-1:0] overlap_add(input logic [2*NSTG-1:0] c,
                                                   input logic f);
    logic [SUM_W-1:0] acc;
    acc = {{(SUM_W-1){1'b0}}, f};
    for (int i = 0; i < NSTG; i++)
      acc = acc + (SUM_W'(c[2*i +: 2]) << (NSTG-1-i));
    return acc;
  endfunction

  logic [SUM_W-1:0] raw_sum;
  assign raw_sum = overlap_add(codes, fin);

  generate
    if (OUT_W >= SUM_W) begin : g_full
      assign sum_out = OUT_W'(raw_sum);
      assign ovf     = 1'b0;
    end else begin : g_clamp
      assign ovf     = |raw_sum[SUM_W-1:OUT_W];
      assign sum_out = ovf ? {OUT_W{1'b1}} : raw_sum[OUT_W-1:0];
    end
  endgenerate

endmodule

// File: rtl/pipe_adc_aligner.sv
`timescale 1ns/1ps
module pipe_adc_aligner #(
  parameter int NSTG  = 8,
  parameter int OUT_W = NSTG + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2*NSTG-1:0] stg_code,
  input  logic              fin_bit,
  input  logic [NSTG:0]     stg_vld,
  output logic [OUT_W-1:0]  word_out,
  output logic              word_vld,
  output logic              code_err
);

  localparam int CODE_W = 2;
  localparam int LANE_W = CODE_W + 1;

  logic [2*NSTG-1:0] aln_code;
  logic [2*NSTG-1:0] fold_w;
  logic [NSTG:0]     aln_vld;
  logic [NSTG-1:0]   aln_bad;
  logic              aln_fin;
  logic              aln_all;
  logic              aln_err;
  logic [OUT_W-1:0]  sum_w;
  logic              sum_ovf;
  logic              fold_any_bad;

  // Stage i waits NSTG-i clocks so it meets the final comparator bit.
  generate
    for (genvar i = 0; i < NSTG; i++) begin : g_lane
      logic [LANE_W-1:0] lane_out;

      pipe_adc_skew_line #(
        .DEPTH(NSTG - i),
        .W    (LANE_W)
      ) u_skew (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({stg_vld[i], stg_code[CODE_W*i +: CODE_W]}),
        .dout (lane_out)
      );

      assign aln_vld[i]                    = lane_out[CODE_W];
      assign aln_code[CODE_W*i +: CODE_W]  = lane_out[CODE_W-1:0];

      pipe_adc_code_fold u_fold (
        .raw   (aln_code[CODE_W*i +: CODE_W]),
        .folded(fold_w[CODE_W*i +: CODE_W]),
        .bad   (aln_bad[i])
      );
    end
  endgenerate

  assign aln_vld[NSTG] = stg_vld[NSTG];
  assign aln_fin       = fin_bit;
  assign aln_all       = &aln_vld;
  assign aln_err       = aln_all & (|aln_bad);

  pipe_adc_overlap_sum #(
    .NSTG (NSTG),
    .OUT_W(OUT_W)
  ) u_sum (
    .codes  (fold_w),
    .fin    (aln_fin),
    .sum_out(sum_w),
    .ovf    (sum_ovf)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_vld <= 1'b0;
      word_out <= '0;
      code_err <= 1'b0;
    end else begin
      word_vld <= aln_all;
      word_out <= aln_all ? sum_w : '0;
      code_err <= aln_err;
    end
  end

  always_comb begin
    fold_any_bad = 1'b0;
    for (int i = 0; i < NSTG; i++)
      if (fold_w[CODE_W*i +: CODE_W] == 2'b11) fold_any_bad = 1'b1;
  end

  // R5
  final_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld |-> $past(stg_vld[NSTG]));

  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !word_vld |-> (word_out == '0 && !code_err));

  // R7
  err_with_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    code_err |-> word_vld);

  // R7
  fold_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fold_any_bad);

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_vld && $past(sum_ovf)) |-> (&word_out));

endmodule

// File: tb/pipe_adc_aligner_bench.sv
`timescale 1ns/1ps
module pipe_adc_aligner_bench;

  localparam int NSTG   = 8;
  localparam int OUT_W  = NSTG + 1;
  localparam int NAR_W  = NSTG;
  localparam int KBITS  = 16;
  localparam int VREF   = 1 << KBITS;
  localparam int VQ     = VREF / 4;
  localparam int MOFF   = VQ - 1;
  localparam int NSAMP  = 600;
  localparam int RUN_LO = 40;
  localparam int RUN_HI = 340;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [2*NSTG-1:0] stg_code = '0;
  logic              fin_bit = 1'b0;
  logic [NSTG:0]     stg_vld = '0;
  logic [OUT_W-1:0]  word_out;
  logic              word_vld;
  logic              code_err;
  logic [NAR_W-1:0]  nar_out;
  logic              nar_vld;
  logic              nar_err;

  always #2.5 clk = ~clk;

  pipe_adc_aligner #(.NSTG(NSTG), .OUT_W(OUT_W)) u_pipe_adc_aligner (
    .clk(clk), .rst_n(rst_n), .stg_code(stg_code), .fin_bit(fin_bit),
    .stg_vld(stg_vld), .word_out(word_out), .word_vld(word_vld), .code_err(code_err));

  pipe_adc_aligner #(.NSTG(NSTG), .OUT_W(NAR_W)) u_pipe_adc_aligner_narrow (
    .clk(clk), .rst_n(rst_n), .stg_code(stg_code), .fin_bit(fin_bit),
    .stg_vld(stg_vld), .word_out(nar_out), .word_vld(nar_vld), .code_err(nar_err));

  logic [2*NSTG-1:0] s_code [NSAMP];
  logic              s_fin  [NSAMP];
  logic [NSTG:0]     s_vld  [NSAMP];
  int                s_exp  [NSAMP];
  bit                s_err  [NSAMP];
  bit                s_ana  [NSAMP];

  int checks = 0;
  int failures = 0;
  int run_seen = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int ceil_scaled(input int v);
    return -((-v) >>> (KBITS - NSTG));
  endfunction

  // Behavioural model of the analog stages with per-comparator offsets.
  task automatic make_analog(input int s, input int vin_in, input int moff);
    int v, th_hi, th_lo, vin;
    vin = vin_in | 1;
    v = vin;
    for (int i = 0; i < NSTG; i++) begin
      th_hi = VQ + int'($urandom_range(2*moff, 0)) - moff;
      th_lo = -VQ + int'($urandom_range(2*moff, 0)) - moff;
      if (v > th_hi) begin
        s_code[s][2*i +: 2] = 2'b10; v = 2*v - VREF;
      end else if (v < th_lo) begin
        s_code[s][2*i +: 2] = 2'b00; v = 2*v + VREF;
      end else begin
        s_code[s][2*i +: 2] = 2'b01; v = 2*v;
      end
    end
    s_fin[s] = (v > 0);
    s_vld[s] = '1;
    s_exp[s] = ceil_scaled(vin) + (1 << NSTG) - 1;
    s_err[s] = 1'b0;
    s_ana[s] = 1'b1;
  endtask

  task automatic make_codes(input int s, input logic [2*NSTG-1:0] c, input logic f);
    int tot;
    bit e;
    tot = int'(f);
    e = 1'b0;
    for (int i = 0; i < NSTG; i++) begin
      if (c[2*i +: 2] == 2'b11) begin
        e = 1'b1;
        tot += 2 * (1 << (NSTG-1-i));
      end else begin
        tot += int'(c[2*i +: 2]) * (1 << (NSTG-1-i));
      end
    end
    s_code[s] = c; s_fin[s] = f; s_vld[s] = '1;
    s_exp[s] = tot; s_err[s] = e; s_ana[s] = 1'b0;
  endtask

  function automatic logic [2*NSTG-1:0] rand_codes(input bit allow_bad);
    logic [2*NSTG-1:0] c;
    for (int i = 0; i < NSTG; i++) begin
      c[2*i +: 2] = 2'($urandom_range(allow_bad ? 3 : 2, 0));
    end
    return c;
  endfunction

  function automatic int rand_vin();
    return int'($urandom_range(2*VREF - 2, 0)) - (VREF - 1);
  endfunction

  task automatic build_samples();
    logic [2*NSTG-1:0] c;
    int k;
    make_analog(0, VREF - 1, MOFF);
    make_analog(1, -(VREF - 1), MOFF);
    make_analog(2, 1, MOFF);
    make_analog(3, -1, MOFF);
    make_analog(4, VQ - 1, MOFF);
    make_analog(5, -VQ + 1, 0);
    make_codes(6, '0, 1'b0);
    for (int i = 0; i < NSTG; i++) c[2*i +: 2] = 2'b10;
    make_codes(7, c, 1'b1);
    make_codes(8, '1, 1'b1);
    c = '0; c[7:6] = 2'b11;
    make_codes(9, c, 1'b0);
    make_analog(10, 12345, MOFF); s_vld[10][NSTG] = 1'b0;
    make_analog(11, -777, MOFF);  s_vld[11][0] = 1'b0;
    for (int s = 12; s < NSAMP; s++) begin
      if (s >= RUN_LO && s < RUN_HI) begin
        make_analog(s, rand_vin(), MOFF);
      end else begin
        k = int'($urandom_range(9, 0));
        if (k < 6) make_analog(s, rand_vin(), MOFF);
        else if (k < 8) make_codes(s, rand_codes(1'b1), 1'($urandom_range(1, 0)));
        else begin
          make_analog(s, rand_vin(), MOFF);
          s_vld[s][$urandom_range(NSTG, 0)] = 1'b0;
        end
      end
    end
  endtask

  task automatic drive_cycle(input int t);
    logic [2*NSTG-1:0] c;
    logic [NSTG:0] v;
    int s;
    for (int i = 0; i < NSTG; i++) begin
      s = t - i;
      if (s >= 0 && s < NSAMP) begin
        c[2*i +: 2] = s_code[s][2*i +: 2]; v[i] = s_vld[s][i];
      end else begin
        c[2*i +: 2] = 2'($urandom_range(3, 0)); v[i] = 1'b0;
      end
    end
    s = t - NSTG;
    if (s >= 0 && s < NSAMP) begin
      fin_bit = s_fin[s]; v[NSTG] = s_vld[s][NSTG];
    end else begin
      fin_bit = 1'($urandom_range(1, 0)); v[NSTG] = 1'b0;
    end
    stg_code = c;
    stg_vld = v;
  endtask

  task automatic check_cycle(input int t);
    int s, nexp;
    bit ev;
    s = t - 1 - NSTG;
    if (s < 0 || s >= NSAMP) begin
      chk("R6", "idle vld", int'(word_vld), 0);
      chk("R6", "idle word", int'(word_out), 0);
      return;
    end
    ev = &s_vld[s];
    chk("R5", $sformatf("vld s=%0d", s), int'(word_vld), int'(ev));
    if (ev) begin
      if (s_ana[s]) chk("R2 R3", $sformatf("word s=%0d", s), int'(word_out), s_exp[s]);
      else          chk("R1 R7", $sformatf("word s=%0d", s), int'(word_out), s_exp[s]);
      chk("R7", $sformatf("err s=%0d", s), int'(code_err), int'(s_err[s]));
      nexp = (s_exp[s] >= (1 << NAR_W)) ? (1 << NAR_W) - 1 : s_exp[s];
      chk("R8", $sformatf("narrow s=%0d", s), int'(nar_out), nexp);
      if (s >= RUN_LO && s < RUN_HI && word_vld) run_seen++;
    end else begin
      chk("R6", $sformatf("word s=%0d", s), int'(word_out), 0);
      chk("R6", $sformatf("err s=%0d", s), int'(code_err), 0);
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_0C0D));
    build_samples();
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9", "reset vld", int'(word_vld), 0);
    chk("R9", "reset word", int'(word_out), 0);
    chk("R9", "reset err", int'(code_err), 0);
    chk("R9", "reset narrow vld", int'(nar_vld), 0);
    rst_n = 1'b1;
    for (int t = 0; t < NSAMP + NSTG + 3; t++) begin
      @(negedge clk);
      check_cycle(t);
      drive_cycle(t);
    end
    // R4 back-to-back run gives a word every clock
    chk("R4", "run words", run_seen, RUN_HI - RUN_LO);

    // R9 reset with samples in flight
    for (int t = 0; t < NSTG + 2; t++) begin
      @(negedge clk);
      stg_code = rand_codes(1'b0);
      stg_vld = '1;
    end
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R9", "async clear vld", int'(word_vld), 0);
    @(negedge clk);
    stg_vld = '0;
    stg_vld[NSTG] = 1'b1;
    rst_n = 1'b1;
    for (int t = 0; t < NSTG + 2; t++) begin
      @(negedge clk);
      chk("R9", $sformatf("flushed vld t=%0d", t), int'(word_vld), 0);
      chk("R9", $sformatf("flushed narrow vld t=%0d", t), int'(nar_vld), 0);
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule